// File: doc/BRIEF.md
# Prescaled PWM Backlight Controller

This block drives one display backlight through a single PWM channel. Software writes a 16-bit configuration word that holds an 8-bit compare value, a polarity bit and a 3-bit power-of-two prescaler select. A separate one-bit clock-select register chooses between two tick-enable sources, a slow one and a system one. The chosen source advances a prescaler, and the prescaler's output advances an 8-bit period counter. One PWM period always lasts 256 prescaled ticks. During the first `compare` ticks of each period the output is in its active phase, so the duty runs from 0/256 to 255/256 and a full-period active level cannot be produced.

The channel is started and stopped by one-cycle write-one strobes on two separate inputs. A request takes effect only at a tick boundary. A status output confirms the change two clocks later, so software has to poll it. Configuration changes made while the channel runs are held back until the current period ends, which keeps every period free of glitches. While the channel is stopped, the output rests at the inactive level that the polarity bit defines, and the counters are held at zero.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: After reset the output is low, the status is 0, the clock select is 0 (slow source) and the configuration word is 0x0010 (compare 0, normal polarity, select 0).
- R2: The configuration word holds the compare value in bits 15:8, the polarity in bit 4 and the prescaler select in bits 2:0. The period counter advances once every 2^select source ticks, and a select of 7 behaves as 6.
- R3: A period lasts 256 prescaled ticks. The active phase covers the counter values below the compare value, so compare 0 gives no active phase and compare 255 leaves one inactive tick in each period.
- R4: With polarity 1 the output is high in the active phase and low otherwise. With polarity 0 both levels are inverted.
- R5: An enable strobe starts the channel at the first source tick after the strobe's cycle. A disable strobe stops it at the first prescaled tick after the strobe's cycle.
- R6: The status output equals the internal run state delayed by two clock cycles.
- R7: While the channel runs, new compare, polarity and select values take effect only after the last tick of a 256-tick period.
- R8: While the channel is stopped, the output holds the inactive level of the current polarity. The prescaler and period counter are zero, so every start begins a fresh period.
- R9: An enable strobe while the channel is running changes neither the output nor the period timing.
- R10: A clock-select value of 1 makes the system tick input drive the prescaler. A value of 0 selects the slow tick input.
- R11: If enable and disable strobes arrive in the same cycle, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Slow source tick enable |
| sys_tick | input | 1 | System source tick enable |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word data |
| sel_wr | input | 1 | Write strobe for the clock-select bit |
| sel_wdata | input | 1 | Clock-select data (1 = system, 0 = slow) |
| en_pulse | input | 1 | Write-one enable strobe |
| dis_pulse | input | 1 | Write-one disable strobe |
| pwm_out | output | 1 | Registered PWM output |
| pwm_running | output | 1 | Running status, two clocks behind the run state |

## Verification
The bench drives the block with a system tick present on every cycle and with a slow tick present every third cycle. Under those sources it uses mid, zero and full compare values, both polarities and the selects 0, 1 and 7. Each combination separates off-by-one errors in the compare from errors in the divider and from select clamping. It also rewrites the configuration in the middle of a period, which shows whether shadow loading happens at the period end or at once. Finally it sends repeated and colliding strobes and a stop followed by a restart, which expose the tick-boundary sequencing, the priority of disable and the counter clearing.

// File: rtl/bl_pwm_pkg.sv
// Package: shared widths and configuration-word field positions for the
// backlight PWM controller. Assumes a 16-bit configuration word.
package bl_pwm_pkg;
    localparam int CFG_W    = 16;
    localparam int CMP_W    = 8;
    localparam int PS_W     = 3;
    localparam int PS_MAX   = 6;
    localparam int CMP_LSB  = 8;
    localparam int POL_BIT  = 4;
    localparam int PS_LSB   = 0;
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h0010;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pol;
        logic [PS_W-1:0]  ps;
    } pwm_cfg_t;

    // Extract the fields from a raw word and clamp the select to PS_MAX.
    function automatic pwm_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        pwm_cfg_t c;
        c.cmp = w[CMP_LSB +: CMP_W];
        c.pol = w[POL_BIT];
        c.ps  = (w[PS_LSB +: PS_W] > PS_W'(PS_MAX)) ? PS_W'(PS_MAX)
                                                   : w[PS_LSB +: PS_W];
        return c;
    endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
// Register file: holds the configuration word, the clock-select bit and the
// run request set and cleared by the write-one strobes.
// Assumes the strobes are one-cycle pulses; disable has priority.
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sel_wr,
    input  logic             sel_wdata,
    input  logic             en_pulse,
    input  logic             dis_pulse,
    output logic [CFG_W-1:0] cfg_q,
    output logic             sel_q,
    output logic             run_req
);
    // Configuration word and clock-select storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            sel_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            if (sel_wr) sel_q <= sel_wdata;
        end
    end

    // Run request: disable wins over a coincident enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_req <= 1'b0;
        else if (dis_pulse) run_req <= 1'b0;
        else if (en_pulse)  run_req <= 1'b1;
    end
endmodule

// File: rtl/bl_pwm_presc.sv
// Prescaler: divides the selected source tick by 2^ps. Held at zero while
// the channel is stopped. Assumes ps never exceeds PS_MAX.
module bl_pwm_presc
    import bl_pwm_pkg::*;
#(
    parameter int PRE_W = PS_MAX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            src_tick,
    input  logic [PS_W-1:0] ps,
    output logic            ptick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Build the terminal count (2^ps - 1), one bit per position.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (PS_W'(i) < ps);
    end

    assign ptick = run && src_tick && (pre_q == mask);

    // Divider counter: wraps at the terminal count, clears when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pre_q <= '0;
        else if (ptick)      pre_q <= '0;
        else if (src_tick)   pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/bl_pwm_gen.sv
// Waveform generator: 256-step period counter, shadowed compare/polarity/
// select and a registered output. The shadow copies the live config while
// stopped and reloads only at the end of a period while running.
module bl_pwm_gen
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ptick,
    input  pwm_cfg_t         live_cfg,
    output pwm_cfg_t         sh_cfg,
    output logic [CMP_W-1:0] cnt_q,
    output logic             period_end,
    output logic             pwm_q
);
    logic active;

    assign period_end = ptick && (cnt_q == '1);
    assign active     = run && (cnt_q < sh_cfg.cmp);

    // Period counter: counts prescaled ticks, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (ptick)     cnt_q <= cnt_q + 1'b1;
    end

    // Shadow registers: follow live config when idle, reload at period end.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sh_cfg <= decode_cfg(CFG_RESET);
        else if (!run || period_end) sh_cfg <= live_cfg;
    end

    // Output register: active phase mapped through the polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= sh_cfg.pol ? active : !active;
    end
endmodule

// File: rtl/bl_pwm_seq.sv
// Sequencer: moves the run state to the request at a tick boundary (source
// tick when stopped, prescaled tick when running) and delays it by two
// flops to form the status. Assumes ticks are single-cycle enables.
module bl_pwm_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic src_tick,
    input  logic ptick,
    output logic run_q,
    output logic status
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Run state: only changes on the relevant tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= 1'b0;
        else if (run_q ? ptick : src_tick) run_q <= run_req;
    end

    // Status delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_q};
    end

    assign status = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/bl_pwm_ctrl.sv
// Top: prescaled PWM backlight controller. Ties the register file, source
// selection, prescaler, generator and sequencer together.
// Assumes slow_tick and sys_tick are enables synchronous to clk.
module bl_pwm_ctrl
    import bl_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_tick,
    input  logic        sys_tick,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    input  logic        sel_wr,
    input  logic        sel_wdata,
    input  logic        en_pulse,
    input  logic        dis_pulse,
    output logic        pwm_out,
    output logic        pwm_running
);
    logic [CFG_W-1:0] cfg_q;
    logic             sel_q;
    logic             run_req;
    logic             run_q;
    logic             src_tick;
    logic             ptick;
    logic             period_end;
    logic [CMP_W-1:0] cnt_q;
    pwm_cfg_t         live_cfg;
    pwm_cfg_t         sh_cfg;

    assign live_cfg = decode_cfg(cfg_q);
    assign src_tick = sel_q ? sys_tick : slow_tick;

    bl_pwm_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .en_pulse(en_pulse), .dis_pulse(dis_pulse),
        .cfg_q(cfg_q), .sel_q(sel_q), .run_req(run_req)
    );

    bl_pwm_presc u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .src_tick(src_tick),
        .ps(sh_cfg.ps), .ptick(ptick)
    );

    bl_pwm_gen u_gen (
        .clk(clk), .rst_n(rst_n), .run(run_q), .ptick(ptick),
        .live_cfg(live_cfg), .sh_cfg(sh_cfg), .cnt_q(cnt_q),
        .period_end(period_end), .pwm_q(pwm_out)
    );

    bl_pwm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .src_tick(src_tick),
        .ptick(ptick), .run_q(run_q), .status(pwm_running)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
// Checker: temporal properties of the controller, bound into the top.
module bl_pwm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_q,
    input logic       ptick,
    input logic       period_end,
    input logic [7:0] cnt_q,
    input logic [7:0] sh_cmp,
    input logic       sh_pol,
    input logic       pwm_out,
    input logic       pwm_running
);
    // R6: status rises only two cycles after the run state was set.
    a_r6_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_running) |-> $past(run_q, 2));

    // R8: one cycle after being stopped, the output is the inactive level.
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_q) |-> (pwm_out == !$past(sh_pol)));

    // R3: the period counter moves only on a prescaled tick.
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(ptick)) |-> $stable(cnt_q));

    // R7: shadow compare holds while running except after a period end.
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(period_end)) |-> $stable(sh_cmp));

    // R5: a running channel stops only on a prescaled tick.
    a_r5_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(ptick));
endmodule

bind bl_pwm_ctrl bl_pwm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .ptick(ptick),
    .period_end(period_end), .cnt_q(cnt_q), .sh_cmp(sh_cfg.cmp),
    .sh_pol(sh_cfg.pol), .pwm_out(pwm_out), .pwm_running(pwm_running)
);

// File: tb/tb_bl_pwm_ctrl.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module tb_bl_pwm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        sys_tick = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        sel_wr = 1'b0;
    logic        sel_wdata = 1'b0;
    logic        en_pulse = 1'b0;
    logic        dis_pulse = 1'b0;
    logic        pwm_out;
    logic        pwm_running;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R1";

    always #4 clk = ~clk;  // 125 MHz

    bl_pwm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .en_pulse(en_pulse), .dis_pulse(dis_pulse),
        .pwm_out(pwm_out), .pwm_running(pwm_running)
    );

    // Reference model state (integers, behaviour from the requirements).
    int m_cfg, m_sel, m_req, m_run, m_pre, m_cnt;
    int m_cmp, m_pol, m_ps, m_pwm, m_st1, m_st2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 16'h0010; m_sel = 0; m_req = 0; m_run = 0; m_pre = 0;
            m_cnt = 0; m_cmp = 0; m_pol = 1; m_ps = 0; m_pwm = 0;
            m_st1 = 0; m_st2 = 0;
        end else begin
            int tick, limit, pt, pe, act, nrun, npre, ncnt;
            tick  = m_sel ? int'(sys_tick) : int'(slow_tick);
            limit = (1 << m_ps) - 1;
            pt    = (m_run && tick && m_pre == limit) ? 1 : 0;
            pe    = (pt && m_cnt == 255) ? 1 : 0;
            act   = (m_run && m_cnt < m_cmp) ? 1 : 0;
            m_pwm = m_pol ? act : 1 - act;
            m_st2 = m_st1;
            m_st1 = m_run;
            nrun  = m_run ? (pt ? m_req : 1) : (tick ? m_req : 0);
            npre  = !m_run ? 0 : (!tick ? m_pre : (m_pre == limit ? 0 : m_pre + 1));
            ncnt  = !m_run ? 0 : (pt ? (m_cnt + 1) % 256 : m_cnt);
            if (!m_run || pe) begin
                m_cmp = (m_cfg >> 8) & 255;
                m_pol = (m_cfg >> 4) & 1;
                m_ps  = m_cfg & 7;
                if (m_ps > 6) m_ps = 6;
            end
            m_req = dis_pulse ? 0 : (en_pulse ? 1 : m_req);
            if (cfg_wr) m_cfg = int'(cfg_wdata);
            if (sel_wr) m_sel = int'(sel_wdata);
            m_run = nrun; m_pre = npre; m_cnt = ncnt;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({tag, " pwm_out"}, int'(pwm_out), m_pwm);
            check("R6 status", int'(pwm_running), m_st2);
        end
    end

    // Slow tick source: one pulse every third cycle.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        slow_tick <= (cyc % 3 == 2);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic v);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic strobe(input logic en, input logic dis);
        @(negedge clk); en_pulse = en; dis_pulse = dis;
        @(negedge clk); en_pulse = 1'b0; dis_pulse = 1'b0;
    endtask

    initial begin
        int high;
        wait_cyc(5);
        rst_n = 1'b1;
        // R1: reset state.
        tag = "R1";
        wait_cyc(1);
        check("R1 out after reset", int'(pwm_out), 0);
        check("R1 status after reset", int'(pwm_running), 0);
        wait_cyc(20);

        // R10: system source, compare 64, normal polarity, select 0.
        tag = "R10";
        wr_sel(1'b1);
        wr_cfg(16'h4010);
        tag = "R5";
        strobe(1'b1, 1'b0);
        wait_cyc(4);
        check("R6 status set after enable", int'(pwm_running), 1);
        wait_cyc(700);

        // R9: second enable while running.
        tag = "R9";
        strobe(1'b1, 1'b0);
        wait_cyc(300);

        // R7: compare change mid-period waits for period end.
        tag = "R7";
        wr_cfg(16'h0A10);
        wait_cyc(600);

        // R8: stop and hold inactive level.
        tag = "R8";
        strobe(1'b0, 1'b1);
        wait_cyc(300);
        check("R8 idle output", int'(pwm_out), 0);
        check("R8 idle status", int'(pwm_running), 0);

        // R4: inverted polarity, compare 200, select 1.
        tag = "R4";
        wr_cfg(16'hC801);
        wait_cyc(3);
        check("R4 idle level inverted", int'(pwm_out), 1);
        strobe(1'b1, 1'b0);
        wait_cyc(1200);

        // R3: compare 0 then 255 with normal polarity.
        tag = "R3";
        wr_cfg(16'h0010);
        wait_cyc(1100);
        wr_cfg(16'hFF10);
        wait_cyc(1100);

        // R11: stop, then collide enable and disable.
        tag = "R11";
        strobe(1'b0, 1'b1);
        wait_cyc(100);
        strobe(1'b1, 1'b1);
        wait_cyc(50);
        check("R11 disable wins", int'(pwm_running), 0);

        // R2: slow source, select 7 clamped to 6, compare 128.
        tag = "R2";
        wr_sel(1'b0);
        wr_cfg(16'h8017);
        strobe(1'b1, 1'b0);
        wait_cyc(100);
        high = 0;
        for (int i = 0; i < 256 * 64 * 3; i++) begin
            @(negedge clk);
            if (pwm_out) high++;
        end
        check("R2 high cycles per period", high, 128 * 64 * 3);
        wait_cyc(50);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule